// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two guesses and picks one of them. The first guess follows each branch's own recent outcomes: a per-branch history register is selected by fetch address bits, and that history then selects a 3-bit confidence counter. The second guess follows the recent outcomes of all branches: a shared path history register selects a 2-bit counter. A third table of 2-bit counters, also selected by the shared path history, decides which guess is trusted.

The fetch side presents an address with a request and receives the guess in the same cycle. It also receives a snapshot that holds the history values and both component guesses used for that guess. The fetch side keeps the snapshot. When the branch resolves, the execute side returns the branch address, the real outcome, the snapshot and a flag that marks a wrong guess. The block trains its tables from the snapshot indices. On a wrong guess it rebuilds the shared path history from the snapshot.

The shared path history advances speculatively with every guess. Later guesses therefore see the predicted path before any branch has resolved.

Top module: `tournament_bp`

## Requirements
- R1: While reset is asserted and right after it is released, all history registers are zero. Every 3-bit local counter holds 3 and every 2-bit global and chooser counter holds 1, which is weakly not-taken (weakly local for the chooser). So the guess is not-taken and the snapshot is all zeros.
- R2: The per-branch history entry is selected by address bits [11:2]. A resolve writes that entry with {snapshot local history[8:0], outcome}. The history used for a guess appears in snapshot bits [21:12].
- R3: The local guess is the MSB of the 3-bit counter selected by the per-branch history. It appears in snapshot bit 23.
- R4: The global guess is the MSB of the 2-bit counter selected by the 12-bit path history. It appears in snapshot bit 22.
- R5: `pred_taken` equals the global guess when the MSB of the chooser counter selected by the path history is 1. Otherwise it equals the local guess.
- R6: The chooser counter at the snapshot path history changes only on a resolve whose snapshot bits 23 and 22 differ. It moves up when the global guess (bit 22) matched the outcome and down otherwise.
- R7: On a predict without a mispredict resolve in the same cycle, the path history becomes {history[10:0], pred_taken}. Snapshot bits [11:0] show the history from before that update.
- R8: A resolve with the mispredict flag set loads the path history with {snapshot bits [10:0], outcome}. This overrides any predict in the same cycle.
- R9: A resolve without the mispredict flag leaves the path history unchanged. It trains the local and global counters with the snapshot indices (up when taken, down when not).
- R10: When a predict and a resolve fall in the same cycle, the guess is formed from the table contents before that cycle's training writes.
- R11: Counters saturate: the 3-bit counters stay within 0 to 7 and the 2-bit counters stay within 0 to 3. Further training in the same direction leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_req | input | 1 | Predict request, advances path history |
| pred_pc | input | 32 | Fetch address of the branch to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_snap | output | 24 | Snapshot: {local guess, global guess, local history, path history} |
| res_valid | input | 1 | Resolve request |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Real outcome (1 = taken) |
| res_mispredict | input | 1 | The earlier guess for this branch was wrong |
| res_snap | input | 24 | Snapshot returned from predict time |

## Verification
The two functions that can land in the same cycle are a predict and a resolve. Either may also carry a mispredict, and both touch the path history and the tables. The bench provokes this by issuing a predict for an address whose earlier guess is being resolved as wrong in that same cycle. Guesses and resolves are also interleaved at random against a queue of in-flight snapshots. A behavioural reference model, updated on every clock, is used to judge each case. The guess must come from the old table contents, the restored history must replace the speculative shift, and every output field must match the model every cycle.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned TP_PC_W   = 32;
  localparam int unsigned TP_PC_LSB = 2;
  localparam int unsigned TP_BHT_N  = 1024;
  localparam int unsigned TP_LH_W   = 10;
  localparam int unsigned TP_LC_W   = 3;
  localparam int unsigned TP_GH_W   = 12;
  localparam int unsigned TP_GC_W   = 2;
  localparam int unsigned TP_CC_W   = 2;

  typedef enum logic {SEL_LOCAL = 1'b0, SEL_GLOBAL = 1'b1} tp_sel_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int unsigned ENTRIES = 4096,
  parameter int unsigned CW      = 2,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CW-1:0]    rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CMIN = '0;
  localparam logic [CW-1:0] CRST = CW'(RST_VAL);

  logic [CW-1:0] tbl [ENTRIES];
  logic [CW-1:0] cur_ctr;
  logic [CW-1:0] nxt_ctr;

  assign rd_ctr  = tbl[rd_idx];
  assign cur_ctr = tbl[wr_idx];

  always_comb begin
    nxt_ctr = cur_ctr;
    if (wr_up) begin
      if (cur_ctr != CMAX) nxt_ctr = cur_ctr + 1'b1;
    end else begin
      if (cur_ctr != CMIN) nxt_ctr = cur_ctr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CRST;
    end else if (wr_en) begin
      tbl[wr_idx] <= nxt_ctr;
    end
  end
endmodule

// File: rtl/tp_lhist_table.sv
module tp_lhist_table #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned HW      = 10,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HW-1:0]    rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [HW-1:0]    wr_hist
);
  logic [HW-1:0] hist [ENTRIES];

  assign rd_hist = hist[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) hist[i] <= '0;
    end else if (wr_en) begin
      hist[wr_idx] <= wr_hist;
    end
  end
endmodule

// File: rtl/tp_ghist_reg.sv
module tp_ghist_reg #(
  parameter int unsigned GH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spec_en,
  input  logic            spec_bit,
  input  logic            restore_en,
  input  logic [GH_W-1:0] restore_base,
  input  logic            restore_bit,
  output logic [GH_W-1:0] ghist
);
  logic [GH_W-1:0] gh_q;
  logic [GH_W-1:0] gh_d;
  logic            gh_en;

  always_comb begin
    gh_d  = gh_q;
    gh_en = 1'b0;
    if (restore_en) begin
      gh_d  = {restore_base[GH_W-2:0], restore_bit};
      gh_en = 1'b1;
    end else if (spec_en) begin
      gh_d  = {gh_q[GH_W-2:0], spec_bit};
      gh_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gh_q <= '0;
    else if (gh_en) gh_q <= gh_d;
  end

  assign ghist = gh_q;
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tp_pkg::*;
#(
  parameter int unsigned PC_W   = TP_PC_W,
  parameter int unsigned PC_LSB = TP_PC_LSB,
  parameter int unsigned BHT_N  = TP_BHT_N,
  parameter int unsigned LH_W   = TP_LH_W,
  parameter int unsigned LC_W   = TP_LC_W,
  parameter int unsigned GH_W   = TP_GH_W,
  parameter int unsigned GC_W   = TP_GC_W,
  parameter int unsigned CC_W   = TP_CC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pred_req,
  input  logic [PC_W-1:0]        pred_pc,
  output logic                   pred_taken,
  output logic [GH_W+LH_W+1:0]   pred_snap,
  input  logic                   res_valid,
  input  logic [PC_W-1:0]        res_pc,
  input  logic                   res_taken,
  input  logic                   res_mispredict,
  input  logic [GH_W+LH_W+1:0]   res_snap
);
  localparam int unsigned BHT_IW  = $clog2(BHT_N);
  localparam int unsigned LCT_N   = 2 ** LH_W;
  localparam int unsigned GCT_N   = 2 ** GH_W;
  localparam int unsigned LC_RST  = 2 ** (LC_W - 1) - 1;
  localparam int unsigned GC_RST  = 2 ** (GC_W - 1) - 1;
  localparam int unsigned CC_RST  = 2 ** (CC_W - 1) - 1;
  localparam int unsigned SNAP_LH = GH_W;
  localparam int unsigned SNAP_GD = GH_W + LH_W;
  localparam int unsigned SNAP_LD = GH_W + LH_W + 1;

  // predict-side signals
  logic [BHT_IW-1:0] p_bht_idx;
  logic [LH_W-1:0]   p_lhist;
  logic [GH_W-1:0]   p_ghist;
  logic [LC_W-1:0]   p_lctr;
  logic [GC_W-1:0]   p_gctr;
  logic [CC_W-1:0]   p_cctr;
  logic              p_ldir;
  logic              p_gdir;
  tp_sel_e           p_sel;

  // resolve-side signals
  logic [BHT_IW-1:0] r_bht_idx;
  logic [GH_W-1:0]   r_gh;
  logic [LH_W-1:0]   r_lh;
  logic              r_gdir;
  logic              r_ldir;
  logic              r_disagree;
  logic              r_restore;
  logic [LH_W-1:0]   r_lh_new;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc, res_pc};

  assign p_bht_idx = pred_pc[PC_LSB +: BHT_IW];
  assign r_bht_idx = res_pc[PC_LSB +: BHT_IW];

  assign r_gh       = res_snap[GH_W-1:0];
  assign r_lh       = res_snap[SNAP_LH +: LH_W];
  assign r_gdir     = res_snap[SNAP_GD];
  assign r_ldir     = res_snap[SNAP_LD];
  assign r_disagree = r_ldir ^ r_gdir;
  assign r_restore  = res_valid & res_mispredict;
  assign r_lh_new   = {r_lh[LH_W-2:0], res_taken};

  tp_lhist_table #(
    .ENTRIES (BHT_N),
    .HW      (LH_W)
  ) u_bht (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (p_bht_idx),
    .rd_hist (p_lhist),
    .wr_en   (res_valid),
    .wr_idx  (r_bht_idx),
    .wr_hist (r_lh_new)
  );

  tp_ctr_table #(
    .ENTRIES (LCT_N),
    .CW      (LC_W),
    .RST_VAL (LC_RST)
  ) u_lct (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_lhist),
    .rd_ctr (p_lctr),
    .wr_en  (res_valid),
    .wr_idx (r_lh),
    .wr_up  (res_taken)
  );

  tp_ctr_table #(
    .ENTRIES (GCT_N),
    .CW      (GC_W),
    .RST_VAL (GC_RST)
  ) u_gct (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_ghist),
    .rd_ctr (p_gctr),
    .wr_en  (res_valid),
    .wr_idx (r_gh),
    .wr_up  (res_taken)
  );

  tp_ctr_table #(
    .ENTRIES (GCT_N),
    .CW      (CC_W),
    .RST_VAL (CC_RST)
  ) u_cct (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_ghist),
    .rd_ctr (p_cctr),
    .wr_en  (res_valid & r_disagree),
    .wr_idx (r_gh),
    .wr_up  (r_gdir == res_taken)
  );

  tp_ghist_reg #(
    .GH_W (GH_W)
  ) u_ghr (
    .clk          (clk),
    .rst_n        (rst_n),
    .spec_en      (pred_req),
    .spec_bit     (pred_taken),
    .restore_en   (r_restore),
    .restore_base (r_gh),
    .restore_bit  (res_taken),
    .ghist        (p_ghist)
  );

  assign p_ldir = p_lctr[LC_W-1];
  assign p_gdir = p_gctr[GC_W-1];
  assign p_sel  = tp_sel_e'(p_cctr[CC_W-1]);

  always_comb begin
    case (p_sel)
      SEL_GLOBAL: pred_taken = p_gdir;
      default:    pred_taken = p_ldir;
    endcase
  end

  assign pred_snap = {p_ldir, p_gdir, p_lhist, p_ghist};
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned GH_W = 12,
  parameter int unsigned LH_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pred_req,
  input logic                 pred_taken,
  input logic [GH_W+LH_W+1:0] pred_snap,
  input logic                 res_valid,
  input logic                 res_taken,
  input logic                 res_mispredict,
  input logic [GH_W+LH_W+1:0] res_snap
);
  localparam int unsigned GD = GH_W + LH_W;
  localparam int unsigned LD = GH_W + LH_W + 1;

  // R1: path history is clear while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (pred_snap[GH_W-1:0] == '0)
        else $error("path history not clear in reset");
    end
  end

  // R7: speculative shift with the guess
  p_spec_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && !(res_valid && res_mispredict)) |=>
      (pred_snap[GH_W-1:0] == {$past(pred_snap[GH_W-2:0]), $past(pred_taken)}));

  // R8: restore from snapshot wins
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |=>
      (pred_snap[GH_W-1:0] == {$past(res_snap[GH_W-2:0]), $past(res_taken)}));

  // R9: history holds without predict or restore
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_req && !(res_valid && res_mispredict)) |=> $stable(pred_snap[GH_W-1:0]));

  // R5: when the two guesses agree, the chooser cannot matter
  p_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_snap[LD] == pred_snap[GD]) |-> (pred_taken == pred_snap[LD]));
endmodule

bind tournament_bp tp_checker #(
  .GH_W (GH_W),
  .LH_W (LH_W)
) u_tp_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .pred_req       (pred_req),
  .pred_taken     (pred_taken),
  .pred_snap      (pred_snap),
  .res_valid      (res_valid),
  .res_taken      (res_taken),
  .res_mispredict (res_mispredict),
  .res_snap       (res_snap)
);

// File: tb/sim_tournament_bp.sv
`timescale 1ns/1ps
module sim_tournament_bp;
  localparam int SW = 24;

  logic          clk;
  logic          rst_n;
  logic          pred_req;
  logic [31:0]   pred_pc;
  logic          pred_taken;
  logic [SW-1:0] pred_snap;
  logic          res_valid;
  logic [31:0]   res_pc;
  logic          res_taken;
  logic          res_mispredict;
  logic [SW-1:0] res_snap;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_bht [1024];
  int m_lc  [1024];
  int m_gc  [4096];
  int m_cc  [4096];
  int m_gh;

  typedef struct {
    logic [31:0]   pc;
    logic [SW-1:0] snap;
    bit            pt;
  } infl_t;
  infl_t q[$];

  tournament_bp u0 (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_snap(pred_snap), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_mispredict(res_mispredict),
    .res_snap(res_snap)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog R1: got timeout exp completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (%s): got %0h exp %0h", req, tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) begin m_bht[i] = 0; m_lc[i] = 3; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_cc[i] = 1; end
    m_gh = 0;
  endtask

  function automatic int up_sat(int v, int mx, bit up);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  // one cycle: drive at negedge, compare, then update the model at posedge
  task automatic step(input bit dp, input logic [31:0] pc, input bit dr,
                      input bit outc, input string tag, input bit after_restore);
    bit misp, ld, gd, pt;
    int lh, li, exp_snap;
    infl_t e;
    @(negedge clk);
    pred_req = dp;
    pred_pc  = pc;
    misp     = 1'b0;
    if (dr && q.size() > 0) begin
      e = q[0];
      misp = (outc != e.pt);
      res_valid = 1'b1; res_pc = e.pc; res_snap = e.snap;
      res_taken = outc; res_mispredict = misp;
    end else begin
      res_valid = 1'b0; res_pc = '0; res_snap = '0;
      res_taken = 1'b0; res_mispredict = 1'b0;
    end
    #1;
    li = (pc >> 2) & 1023;
    lh = m_bht[li];
    ld = m_lc[lh] >= 4;
    gd = m_gc[m_gh] >= 2;
    pt = (m_cc[m_gh] >= 2) ? gd : ld;
    exp_snap = (int'(ld) << 23) | (int'(gd) << 22) | (lh << 12) | m_gh;
    chk("R5", tag, int'(pred_taken), int'(pt));
    chk("R3", tag, int'(pred_snap[23]), int'(ld));
    chk("R4", tag, int'(pred_snap[22]), int'(gd));
    chk("R2", tag, int'(pred_snap[21:12]), lh);
    chk(after_restore ? "R8" : "R7", tag, int'(pred_snap[11:0]), m_gh);
    @(posedge clk);
    if (res_valid) begin
      int sgh, slh, ri;
      bit sld, sgd;
      sgh = int'(res_snap[11:0]);
      slh = int'(res_snap[21:12]);
      sgd = res_snap[22];
      sld = res_snap[23];
      ri  = (res_pc >> 2) & 1023;
      m_bht[ri] = ((slh << 1) | int'(outc)) & 1023;
      m_lc[slh] = up_sat(m_lc[slh], 7, outc);
      m_gc[sgh] = up_sat(m_gc[sgh], 3, outc);
      if (sld != sgd) m_cc[sgh] = up_sat(m_cc[sgh], 3, sgd == outc);
      if (misp) m_gh = ((sgh << 1) | int'(outc)) & 4095;
      else if (dp) m_gh = ((m_gh << 1) | int'(pt)) & 4095;
      void'(q.pop_front());
    end else if (dp) begin
      m_gh = ((m_gh << 1) | int'(pt)) & 4095;
    end
    if (misp) q.delete();
    else if (dp) begin
      e.pc = pc; e.snap = pred_snap; e.pt = pt;
      q.push_back(e);
    end
  endtask

  initial begin
    logic [31:0] pcs [8];
    bit last_misp;
    rst_n = 1'b0; pred_req = 1'b0; pred_pc = '0; res_valid = 1'b0;
    res_pc = '0; res_taken = 1'b0; res_mispredict = 1'b0; res_snap = '0;
    model_reset();
    for (int i = 0; i < 8; i++) pcs[i] = 32'h0000_4000 + 32'(i * 52);
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk("R1", "in reset", int'(pred_taken), 0);
    chk("R1", "in reset", int'(pred_snap), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release, weakly not-taken everywhere
    step(1'b0, 32'h100, 1'b0, 1'b0, "R1 post-reset", 1'b0);

    // R11: saturate one branch taken, then untrain it
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 32'h200, 1'b0, 1'b0, "R11 up predict", 1'b0);
      step(1'b0, 32'h200, 1'b1, 1'b1, "R11 up resolve", 1'b0);
    end
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 32'h200, 1'b0, 1'b0, "R11 down predict", 1'b0);
      step(1'b0, 32'h200, 1'b1, 1'b0, "R11 down resolve", 1'b0);
    end

    // R10 / R8: predict and resolve-with-mispredict in the same cycle
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 32'h300, 1'b0, 1'b0, "R10 setup", 1'b0);
      step(1'b1, 32'h300, 1'b1, ~q[0].pt, "R10 same-cycle", 1'b0);
      step(1'b0, 32'h300, 1'b0, 1'b0, "R8 after restore", 1'b1);
      step(1'b1, 32'h300, 1'b0, 1'b0, "R10 setup2", 1'b0);
      step(1'b1, 32'h304, 1'b1, q[0].pt, "R10 correct same-cycle", 1'b0);
      step(1'b0, 32'h304, 1'b1, 1'b1, "R9 drain", 1'b0);
    end

    // R6 / R9: random interleaving with per-branch behaviour
    last_misp = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      int  sel;
      bit  dp, dr, outc, mp;
      sel = int'($urandom_range(0, 7));
      dp  = ($urandom_range(0, 3) != 0);
      dr  = (q.size() > 12) || ($urandom_range(0, 1) == 1);
      outc = 1'b0;
      mp   = 1'b0;
      if (q.size() > 0) begin
        int ps;
        ps = int'((q[0].pc - 32'h0000_4000) / 52);
        case (ps)
          0, 1: outc = 1'b1;
          2:    outc = 1'b0;
          3:    outc = q[0].snap[0];
          4:    outc = ~q[0].snap[12];
          default: outc = ($urandom_range(0, 3) != 0);
        endcase
        mp = dr && (outc != q[0].pt);
      end
      step(dp, pcs[sel], dr, outc, "R6/R9 random", last_misp);
      last_misp = mp;
    end

    @(negedge clk);
    pred_req = 1'b0; res_valid = 1'b0;
    summary();
    $finish;
  end
endmodule